// File: doc/BRIEF.md
# Half-Width Panel Line Interleaver

This block produces the pixel stream for one line of a parallax-barrier panel whose physical pixels are half as wide as usual. The panel line is 800 physical pixels wide and a frame has 240 lines. For each line the block walks the physical columns and fetches source pixels from two external eye-line buffers, one for the left eye and one for the right. It sends out one 24-bit RGB pixel per physical column, with a valid pulse and an end-of-line marker.

Three layouts are available. In stereo layout the line is column-interleaved from two 400-pixel eye lines, so both eye images are on the panel at once. In flat layout every source pixel from the left buffer fills a pair of adjacent physical pixels, which gives an effective 400-pixel line. In native layout a single 800-pixel source line maps one to one onto the panel. A layout code is sampled only on a line-start strobe. Everything advances on a pixel-clock enable, so the block can run from a fast system clock.

Top module: `stereo_line_interleaver`

## Requirements
- R1: After reset `pix_valid_o`, `eol_o` and `pix_o` are all zero, and no pixel is produced until a line-start strobe is seen.
- R2: Each line-start strobe produces exactly 800 valid pixel pulses, one per physical column from 0 to 799 in order. No further pulses follow until the next strobe.
- R3: The strobe is sampled on an enabled clock edge, which counts as edge 0. The pixel for physical column c is presented after enabled edge c+2.
- R4: Layout code 1 (stereo): even column c shows left-buffer pixel c/2, and odd column c shows right-buffer pixel (c-1)/2.
- R5: Layout code 0 (flat): columns 2k and 2k+1 both show left-buffer pixel k. Code 3 behaves the same as code 0.
- R6: Layout code 2 (native): column c shows left-buffer pixel c.
- R7: `rd_addr_o` is floor(column/2) for codes 0, 1 and 3, and equals the column for code 2. `rd_en_o` follows `pix_en`. Both buffers must register an enabled read and return its data on the next clock.
- R8: A change on `mode_i` between strobes has no effect on the line in progress. The new code applies from the next strobe.
- R9: `eol_o` is high only together with the pixel of column 799.
- R10: When `pix_en` is low the pipeline holds. Each valid pulse lasts a single clock, and no pixel is lost or repeated, whatever the spacing of enables.
- R11: A strobe in the middle of a line restarts at column 0. Columns already fetched are still delivered first: exactly one pixel for each enabled edge from the earlier strobe up to the edge before the new one.
- R12: Pixels pass unchanged as 24 bits: red in bits 23:16, green in 15:8, blue in 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable; the pipeline advances on enabled edges |
| line_start | input | 1 | Line-start strobe, sampled with `pix_en` |
| mode_i | input | 2 | Layout code: 0 flat, 1 stereo, 2 native, 3 same as flat |
| rd_addr_o | output | 10 | Read address for both eye-line buffers |
| rd_en_o | output | 1 | Read enable for both buffers |
| left_data_i | input | 24 | Left-buffer read data, one clock after an enabled read |
| right_data_i | input | 24 | Right-buffer read data, one clock after an enabled read |
| pix_o | output | 24 | RGB pixel to the panel |
| pix_valid_o | output | 1 | One-clock pulse marking a new pixel on `pix_o` |
| eol_o | output | 1 | High with the pixel of column 799 |

## Verification
The strobe edge counts as edge 0. A column's address shows on `rd_addr_o` after the enabled edge that reaches that column. Buffer data follows one clock later, and the pixel is presented after the second enabled edge after the address, so column c is due after enabled edge c+2. The driver puts each line's expected pixels into a queue before it raises the strobe. The monitor samples on the falling clock edge and takes one item from the queue for every valid pulse, so timing with gaps in the enables is checked by order and count, not by fixed offsets. Fixed-offset checks of address and first-pixel latency are made directly after known enabled edges in stereo and native lines.

// File: rtl/il_pkg.sv
package il_pkg;
  typedef enum logic [1:0] {
    LAYOUT_FLAT   = 2'd0,
    LAYOUT_STEREO = 2'd1,
    LAYOUT_NATIVE = 2'd2,
    LAYOUT_ALT    = 2'd3
  } layout_e;

  function automatic logic halves_column(input layout_e m);
    return (m != LAYOUT_NATIVE);
  endfunction
endpackage

// File: rtl/il_col_seq.sv
module il_col_seq
  import il_pkg::*;
#(
  parameter int LINE_W = 800,
  localparam int AW = $clog2(LINE_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          line_start,
  input  logic [1:0]    mode_i,
  output logic [AW-1:0] col_o,
  output logic          active_o,
  output logic          last_o,
  output layout_e       layout_o
);
  localparam logic [AW-1:0] LAST_COL = AW'(LINE_W - 1);

  logic [AW-1:0] col_q;
  logic          active_q;
  layout_e       layout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q    <= '0;
      active_q <= 1'b0;
      layout_q <= LAYOUT_FLAT;
    end else if (pix_en) begin
      if (line_start) begin
        col_q    <= '0;
        active_q <= 1'b1;
        layout_q <= layout_e'(mode_i);
      end else if (active_q) begin
        if (col_q == LAST_COL) begin
          active_q <= 1'b0;
        end else begin
          col_q <= col_q + AW'(1);
        end
      end
    end
  end

  assign col_o    = col_q;
  assign active_o = active_q;
  assign last_o   = (col_q == LAST_COL);
  assign layout_o = layout_q;

  AST_LAYOUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !(pix_en && line_start) |=> $stable(layout_q)); // R8
  AST_COL_BOUND: assert property (@(posedge clk) disable iff (rst)
    col_q <= LAST_COL); // R2
endmodule

// File: rtl/il_addr_gen.sv
module il_addr_gen
  import il_pkg::*;
#(
  parameter int LINE_W = 800,
  localparam int AW = $clog2(LINE_W)
) (
  input  logic [AW-1:0] col_i,
  input  layout_e       layout_i,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    if (halves_column(layout_i)) addr_o = col_i >> 1;
    else                         addr_o = col_i;
  end
endmodule

// File: rtl/il_pix_sel.sv
module il_pix_sel
  import il_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_en,
  input  logic             cur_vld_i,
  input  logic             cur_odd_i,
  input  logic             cur_last_i,
  input  layout_e          cur_layout_i,
  input  logic [PIX_W-1:0] left_data_i,
  input  logic [PIX_W-1:0] right_data_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             valid_o,
  output logic             eol_o
);
  logic    fch_vld, fch_odd, fch_last;
  layout_e fch_layout;
  logic [PIX_W-1:0] chosen;

  always_ff @(posedge clk) begin
    if (rst) begin
      fch_vld    <= 1'b0;
      fch_odd    <= 1'b0;
      fch_last   <= 1'b0;
      fch_layout <= LAYOUT_FLAT;
    end else if (pix_en) begin
      fch_vld    <= cur_vld_i;
      fch_odd    <= cur_odd_i;
      fch_last   <= cur_last_i;
      fch_layout <= cur_layout_i;
    end
  end

  always_comb begin
    if (fch_layout == LAYOUT_STEREO && fch_odd) chosen = right_data_i;
    else                                         chosen = left_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_o   <= '0;
      valid_o <= 1'b0;
      eol_o   <= 1'b0;
    end else if (pix_en) begin
      valid_o <= fch_vld;
      eol_o   <= fch_vld && fch_last;
      pix_o   <= fch_vld ? chosen : '0;
    end else begin
      valid_o <= 1'b0;
      eol_o   <= 1'b0;
    end
  end

  AST_EOL_WITH_PIXEL: assert property (@(posedge clk) disable iff (rst)
    eol_o |-> valid_o); // R9
  AST_PULSE_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(pix_en)); // R10
endmodule

// File: rtl/stereo_line_interleaver.sv
module stereo_line_interleaver
  import il_pkg::*;
#(
  parameter int LINE_W = 800,
  parameter int CH_W   = 8,
  localparam int AW    = $clog2(LINE_W),
  localparam int PIX_W = 3 * CH_W,
  localparam int HALF_W = LINE_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_en,
  input  logic             line_start,
  input  logic [1:0]       mode_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic             rd_en_o,
  input  logic [PIX_W-1:0] left_data_i,
  input  logic [PIX_W-1:0] right_data_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             pix_valid_o,
  output logic             eol_o
);
  logic [AW-1:0] col;
  logic          active, last;
  layout_e       layout;

  il_col_seq #(.LINE_W(LINE_W)) u_seq (
    .clk(clk), .rst(rst), .pix_en(pix_en), .line_start(line_start),
    .mode_i(mode_i), .col_o(col), .active_o(active), .last_o(last),
    .layout_o(layout)
  );

  il_addr_gen #(.LINE_W(LINE_W)) u_addr (
    .col_i(col), .layout_i(layout), .addr_o(rd_addr_o)
  );

  assign rd_en_o = pix_en;

  il_pix_sel #(.PIX_W(PIX_W)) u_sel (
    .clk(clk), .rst(rst), .pix_en(pix_en),
    .cur_vld_i(active), .cur_odd_i(col[0]), .cur_last_i(last),
    .cur_layout_i(layout),
    .left_data_i(left_data_i), .right_data_i(right_data_i),
    .pix_o(pix_o), .valid_o(pix_valid_o), .eol_o(eol_o)
  );

  AST_ADDR_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    rd_addr_o < AW'(LINE_W)); // R7
  AST_ADDR_HALF_SPAN: assert property (@(posedge clk) disable iff (rst)
    (layout != LAYOUT_NATIVE) |-> (rd_addr_o < AW'(HALF_W))); // R7
endmodule

// File: tb/tb_stereo_line_interleaver.sv
module tb_stereo_line_interleaver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_en = 1'b0;
  logic        line_start = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [9:0]  rd_addr_o;
  logic        rd_en_o;
  logic [23:0] left_data_i, right_data_i;
  logic [23:0] pix_o;
  logic        pix_valid_o, eol_o;

  int n_run = 0;
  int n_fail = 0;
  logic [24:0] expq[$];

  always #2.5 clk = ~clk;

  stereo_line_interleaver dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .line_start(line_start),
    .mode_i(mode_i), .rd_addr_o(rd_addr_o), .rd_en_o(rd_en_o),
    .left_data_i(left_data_i), .right_data_i(right_data_i),
    .pix_o(pix_o), .pix_valid_o(pix_valid_o), .eol_o(eol_o)
  );

  function automatic logic [23:0] lpix(input logic [9:0] i);
    return {i[7:0] ^ 8'h5A, i[9:2], 8'hC3 ^ i[8:1]};
  endfunction
  function automatic logic [23:0] rpix(input logic [9:0] i);
    return {~i[7:0], 8'h3C, i[8:1] ^ 8'h81};
  endfunction

  // Buffer models: enabled read registered, data on the next clock (R7)
  always_ff @(posedge clk) begin
    if (rd_en_o) begin
      left_data_i  <= lpix(rd_addr_o);
      right_data_i <= (rd_addr_o < 10'd400) ? rpix(rd_addr_o) : 24'h0;
    end
  end

  function automatic logic [23:0] expect_pix(input logic [1:0] m, input int c);
    logic [9:0] h;
    h = 10'(c / 2);
    case (m)
      2'd1:    return (c % 2 == 1) ? rpix(h) : lpix(h); // R4
      2'd2:    return lpix(10'(c));                     // R6
      default: return lpix(h);                          // R5
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_line(input logic [1:0] m, input int ncols);
    for (int c = 0; c < ncols; c++)
      expq.push_back({(c == 799), expect_pix(m, c)});
  endtask

  task automatic strobe(input logic [1:0] m);
    line_start = 1'b1; mode_i = m; pix_en = 1'b1;
    @(negedge clk);
    line_start = 1'b0; pix_en = 1'b0;
  endtask

  task automatic run(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      pix_en = 1'b1;
      @(negedge clk);
      pix_en = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic idle_and_drain();
    run(6, 0);
    repeat (4) @(negedge clk);
    chk("R2 leftover expected pixels", expq.size(), 0);
  endtask

  // Scoreboard monitor (R2, R9, R10, R12)
  always @(negedge clk) begin
    if (!rst) begin
      if (pix_valid_o) begin
        if (expq.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R2 unexpected pixel actual=%06h expected=none", pix_o);
        end else begin
          logic [24:0] e;
          e = expq.pop_front();
          n_run++;
          if (pix_o !== e[23:0] || eol_o !== e[24]) begin
            n_fail++;
            $display("FAIL R12/R9 pixel actual=%06h eol=%0b expected=%06h eol=%0b",
                     pix_o, eol_o, e[23:0], e[24]);
          end
        end
      end else if (eol_o) begin
        n_run++; n_fail++;
        $display("FAIL R9 eol without pixel actual=1 expected=0");
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid after reset", int'(pix_valid_o), 0);
    chk("R1 eol after reset", int'(eol_o), 0);
    chk("R1 pix after reset", int'(pix_o), 0);
    run(5, 0);
    chk("R1 no pixel before strobe", int'(pix_valid_o), 0);

    // R4 stereo line, address checks R7
    push_line(2'd1, 800);
    strobe(2'd1);
    chk("R7 stereo addr col0", int'(rd_addr_o), 0);
    chk("R7 read enable follows pix_en", int'(rd_en_o), 0);
    run(1, 0);
    chk("R7 stereo addr col1", int'(rd_addr_o), 0);
    run(1, 0);
    chk("R7 stereo addr col2", int'(rd_addr_o), 1);
    run(799, 0);
    idle_and_drain();

    // R5 flat layout with enable gaps (R10)
    push_line(2'd0, 800);
    strobe(2'd0);
    run(801, 2);
    idle_and_drain();

    // R6 native with latency check (R3)
    push_line(2'd2, 800);
    strobe(2'd2);
    chk("R3 no pixel after edge0", int'(pix_valid_o), 0);
    chk("R7 native addr col0", int'(rd_addr_o), 0);
    run(1, 0);
    chk("R3 no pixel after edge1", int'(pix_valid_o), 0);
    chk("R7 native addr col1", int'(rd_addr_o), 1);
    pix_en = 1'b1;
    chk("R7 read enable high", int'(rd_en_o), 1);
    @(negedge clk);
    pix_en = 1'b0;
    chk("R3 pixel after edge2", int'(pix_valid_o), 1);
    chk("R7 native addr col2", int'(rd_addr_o), 2);
    run(799, 0);
    idle_and_drain();

    // R5 code 3 same as flat, irregular gaps (R10)
    push_line(2'd3, 800);
    strobe(2'd3);
    for (int k = 0; k < 801; k++) run(1, k % 3);
    idle_and_drain();

    // R8 mode change mid-line ignored
    push_line(2'd1, 800);
    strobe(2'd1);
    run(100, 0);
    mode_i = 2'd2;
    run(701, 0);
    idle_and_drain();

    // R11 restart mid-line: 51 old columns, then a full flat line
    push_line(2'd1, 51);
    strobe(2'd1);
    run(50, 0);
    push_line(2'd0, 800);
    strobe(2'd0);
    run(801, 1);
    idle_and_drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule